// File: doc/BRIEF.md
# Two-Tier Chained Bus Arbiter

This block decides which bus master may drive a shared system bus. Masters sit in four arbitration levels. Inside a level, every slot's request is OR-ed onto one level request, and every slot's busy flag is OR-ed onto one level busy. A single level grant enters slot 0 and travels upward from slot to slot. The first slot that is requesting stops it and takes the bus. A slot that is not requesting passes the grant to the next slot. Position in the chain therefore sets priority inside a level.

Between levels, a central arbiter picks one requesting level under a discipline chosen at run time. The choices are a fixed order, a rotating order in which the level just served drops to the bottom, or a round-robin pointer. A shared inhibit output forces the bus owner off the bus in two cases: a level of higher rank asks for the bus, or the owner's tenure exceeds a programmed limit. The owner must drop busy when inhibit is high. Once every busy line is low, inhibit falls and the next grant follows.

The masters' own transfer logic lives outside this block. Masters see only their grant and the inhibit line. They report ownership through busy.

Top module: `lvl_chain_arbiter`

## Requirements
- R1: After reset, all slot grants and inhibit are low, the discipline is fixed, the tenure limit is off (0), the rotating order is 0,1,2,3 and the round-robin pointer is at level 0.
- R2: Inside a level, the grant goes to the requesting slot with the lowest slot number (slot index = level*SLOTS + position). Slots that are not requesting pass the grant on. At most one slot grant is high at any time.
- R3: When no busy line is high and some level requests, one level grant is registered. The chosen slot's grant is visible in the cycle after its request is first presented. No grant is issued while any busy line is high.
- R4: Fixed discipline (mode 0, and mode 3): the lowest-numbered requesting level wins.
- R5: Rotating discipline (mode 1): when a level s releases the bus, level s+1 (mod 4) becomes the highest, and the others follow in circular order.
- R6: Round-robin discipline (mode 2): each release moves the pointer on by one level. The search for a winner starts at the pointer and skips levels that have no request.
- R7: In fixed and rotating modes, a request from a level of higher rank than the owner raises inhibit in the cycle after the request is presented. Round-robin mode never preempts on requests. A level of lower rank never causes preemption.
- R8: With a tenure limit T > 0, inhibit rises T+1 cycles after the cycle in which the owner's slot grant is shown, if the owner still holds busy. A limit of 0 disables the timer.
- R9: Inhibit falls in the cycle after every busy line is low. The next grant is registered one cycle after that.
- R10: A mode written while the bus is owned does not apply until the arbiter returns to idle. Preemption during that tenure follows the old mode. A write of cfg_we loads both the mode and the tenure limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | input | NUM_LVL*SLOTS | Per-slot bus request, slot index level*SLOTS+position |
| slot_busy | input | NUM_LVL*SLOTS | Per-slot busy (bus owned by that slot) |
| cfg_we | input | 1 | Load mode and tenure limit |
| cfg_mode | input | 2 | Discipline: 0 fixed, 1 rotating, 2 round-robin, 3 fixed |
| cfg_timeout | input | TMR_W | Tenure limit in cycles, 0 disables |
| slot_grant | output | NUM_LVL*SLOTS | Per-slot grant out of each level chain |
| inhibit | output | 1 | Global bus release request to all masters |

## Verification
The bench builds the block with four levels, three slots per level and an 8-bit tenure timer. Three slots per level are enough to show a grant skipping a silent slot and then being blocked by a later one, while all twelve slots stay easy to drive by hand. Short holds and a tenure limit of 4 let a single run cover preemption, timer expiry, release and re-grant of a preempted master, and a mode change that is held back until idle. Each discipline's order is checked against sequences worked out by hand from the rules above.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam logic [1:0] DISC_FIXED  = 2'd0;
    localparam logic [1:0] DISC_ROTATE = 2'd1;
    localparam logic [1:0] DISC_RROBIN = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_OWN   = 2'd2,
        ST_DRAIN = 2'd3
    } arb_st_e;

    // distance of level a behind start level s in circular order of n levels
    function automatic int circ_dist(input int a, input int s, input int n);
        return (a - s + n) % n;
    endfunction

endpackage

// File: rtl/arb_slot_chain.sv
module arb_slot_chain #(
    parameter int SLOTS = 3
) (
    input  logic             grant_in,
    input  logic [SLOTS-1:0] req,
    output logic [SLOTS-1:0] grant
);
    // pass[i] is the grant arriving at slot i; pass[i+1] is slot i's grant-out
    logic [SLOTS:0] pass;
    assign pass[0] = grant_in;

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign grant[i]  = pass[i] & req[i];
        assign pass[i+1] = pass[i] & ~req[i];
    end

endmodule

// File: rtl/arb_level_pick.sv
module arb_level_pick #(
    parameter int NUM_LVL = 4,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic [NUM_LVL-1:0] req,
    input  logic [LW-1:0]      start,
    output logic [LW-1:0]      win,
    output logic               win_vld
);
    always_comb begin
        win     = '0;
        win_vld = 1'b0;
        for (int k = 0; k < NUM_LVL; k++) begin
            int idx;
            idx = (int'(start) + k) % NUM_LVL;
            if (!win_vld && req[idx]) begin
                win_vld = 1'b1;
                win     = idx[LW-1:0];
            end
        end
    end

endmodule

// File: rtl/arb_level_core.sv
module arb_level_core
    import arb_pkg::*;
#(
    parameter int NUM_LVL = 4,
    parameter int TMR_W   = 8,
    localparam int LW = $clog2(NUM_LVL)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] lvl_req,
    input  logic [NUM_LVL-1:0] lvl_busy,
    input  logic               cfg_we,
    input  logic [1:0]         cfg_mode,
    input  logic [TMR_W-1:0]   cfg_timeout,
    output logic [NUM_LVL-1:0] lvl_grant,
    output logic               inhibit
);
    typedef struct packed {
        arb_st_e            st;
        logic [NUM_LVL-1:0] gnt;
        logic [LW-1:0]      own;
        logic               inh;
        logic [LW-1:0]      top;
        logic [LW-1:0]      ptr;
        logic [TMR_W-1:0]   tmr;
        logic [1:0]         mode;
        logic [1:0]         pend;
        logic [TMR_W-1:0]   tmo;
    } core_s;

    core_s d, q;

    logic [1:0]    eff_mode;
    logic [LW-1:0] start;
    logic [LW-1:0] win;
    logic          win_vld;
    logic          any_busy;
    logic          preempt;
    logic          expire;

    assign eff_mode = (q.st == ST_IDLE) ? q.pend : q.mode;
    assign any_busy = |lvl_busy;

    always_comb begin
        case (eff_mode)
            DISC_ROTATE: start = q.top;
            DISC_RROBIN: start = q.ptr;
            default:     start = '0;
        endcase
    end

    arb_level_pick #(.NUM_LVL(NUM_LVL)) u_pick (
        .req     (lvl_req),
        .start   (start),
        .win     (win),
        .win_vld (win_vld)
    );

    assign preempt = (q.mode != DISC_RROBIN) && win_vld && (win != q.own) &&
                     (circ_dist(int'(win), int'(start), NUM_LVL) <
                      circ_dist(int'(q.own), int'(start), NUM_LVL));
    assign expire  = (q.tmo != '0) && (q.tmr == q.tmo - 1'b1);

    function automatic logic [LW-1:0] lvl_next(input logic [LW-1:0] v);
        return (v == LW'(NUM_LVL - 1)) ? '0 : v + 1'b1;
    endfunction

    always_comb begin
        d = q;
        if (cfg_we) begin
            d.pend = cfg_mode;
            d.tmo  = cfg_timeout;
        end
        case (q.st)
            ST_IDLE: begin
                d.mode = q.pend;
                if (!any_busy && win_vld) begin
                    d.gnt      = '0;
                    d.gnt[win] = 1'b1;
                    d.own      = win;
                    d.st       = ST_GRANT;
                end
            end
            ST_GRANT: begin
                if (lvl_busy[q.own]) begin
                    d.gnt = '0;
                    d.tmr = '0;
                    d.st  = ST_OWN;
                end else if (!lvl_req[q.own]) begin
                    d.gnt = '0;
                    d.st  = ST_IDLE;
                end
            end
            ST_OWN: begin
                if (!lvl_busy[q.own]) begin
                    d.st = ST_IDLE;
                    if (q.mode == DISC_ROTATE) d.top = lvl_next(q.own);
                    if (q.mode == DISC_RROBIN) d.ptr = lvl_next(q.ptr);
                end else if (preempt || expire) begin
                    d.inh = 1'b1;
                    d.st  = ST_DRAIN;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            default: begin
                if (!any_busy) begin
                    d.inh = 1'b0;
                    d.st  = ST_IDLE;
                    if (q.mode == DISC_ROTATE) d.top = lvl_next(q.own);
                    if (q.mode == DISC_RROBIN) d.ptr = lvl_next(q.ptr);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mode: DISC_FIXED, pend: DISC_FIXED, default: '0};
        end else begin
            q <= d;
        end
    end

    assign lvl_grant = q.gnt;
    assign inhibit   = q.inh;

    assert_level_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lvl_grant));

    assert_grant_bus_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|lvl_grant) |-> $past(~|lvl_busy));

    assert_inhibit_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(inhibit) |-> $past(~|lvl_busy));

    assert_mode_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.mode) |-> $past(q.st == ST_IDLE));

    assert_no_rr_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_OWN && q.mode == DISC_RROBIN && q.tmo == '0) |=> !inhibit);

endmodule

// File: rtl/lvl_chain_arbiter.sv
module lvl_chain_arbiter #(
    parameter int NUM_LVL = 4,
    parameter int SLOTS   = 3,
    parameter int TMR_W   = 8,
    localparam int NSLOT = NUM_LVL * SLOTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] slot_req,
    input  logic [NSLOT-1:0] slot_busy,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [TMR_W-1:0] cfg_timeout,
    output logic [NSLOT-1:0] slot_grant,
    output logic             inhibit
);
    logic [NUM_LVL-1:0] lvl_req;
    logic [NUM_LVL-1:0] lvl_busy;
    logic [NUM_LVL-1:0] lvl_grant;

    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        assign lvl_req[l]  = |slot_req[l*SLOTS +: SLOTS];
        assign lvl_busy[l] = |slot_busy[l*SLOTS +: SLOTS];

        arb_slot_chain #(.SLOTS(SLOTS)) u_chain (
            .grant_in (lvl_grant[l]),
            .req      (slot_req[l*SLOTS +: SLOTS]),
            .grant    (slot_grant[l*SLOTS +: SLOTS])
        );
    end

    arb_level_core #(.NUM_LVL(NUM_LVL), .TMR_W(TMR_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .lvl_req     (lvl_req),
        .lvl_busy    (lvl_busy),
        .cfg_we      (cfg_we),
        .cfg_mode    (cfg_mode),
        .cfg_timeout (cfg_timeout),
        .lvl_grant   (lvl_grant),
        .inhibit     (inhibit)
    );

    assert_slot_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_grant));

endmodule

// File: tb/tb_lvl_chain_arbiter.sv
`timescale 1ns/1ps
module tb_lvl_chain_arbiter;
    localparam int NL = 4;
    localparam int NS = 3;
    localparam int NT = NL * NS;
    localparam int TW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NT-1:0] req = '0;
    logic [NT-1:0] busy = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [TW-1:0] cfg_tmo = '0;
    logic [NT-1:0] gnt;
    logic          inh;

    lvl_chain_arbiter #(.NUM_LVL(NL), .SLOTS(NS), .TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .slot_req(req), .slot_busy(busy),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_timeout(cfg_tmo),
        .slot_grant(gnt), .inhibit(inh)
    );

    typedef struct { int idx; string tag; } exp_t;
    exp_t expq[$];
    int checks = 0;
    int errors = 0;
    int inh_rises = 0;
    int hold[NT];
    int cnt[NT];
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int idx_of(input logic [NT-1:0] v);
        for (int i = 0; i < NT; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic expect_g(input int i, input string tag);
        exp_t e;
        e.idx = i;
        e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic cfg(input logic [1:0] m, input int t);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mode = m; cfg_tmo = TW'(t);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_quiet();
        int qn = 0;
        while (qn < 3) begin
            @(negedge clk);
            if (req == '0 && busy == '0 && !inh) qn++;
            else qn = 0;
        end
    endtask

    // monitor (scoreboard) and master model
    initial begin
        logic [NT-1:0] pg;
        logic pi;
        pg = '0;
        pi = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (gnt != '0 && pg == '0) begin
                    int a;
                    a = idx_of(gnt);
                    if (expq.size() == 0) chk(0, "R2", "unexpected grant", a, -1);
                    else begin
                        exp_t e;
                        e = expq.pop_front();
                        chk(a == e.idx, e.tag, "grant slot", a, e.idx);
                    end
                end
                if (inh && !pi) inh_rises++;
                pg = gnt;
                pi = inh;
                for (int i = 0; i < NT; i++) begin
                    if (gnt[i] && !busy[i]) begin
                        busy[i] = 1'b1;
                        cnt[i] = hold[i];
                    end else if (busy[i]) begin
                        if (inh) begin
                            busy[i] = 1'b0;
                            hold[i] = 2;
                        end else begin
                            cnt[i]--;
                            if (cnt[i] == 0) begin
                                busy[i] = 1'b0;
                                req[i] = 1'b0;
                            end
                        end
                    end
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < NT; i++) hold[i] = 3;
        repeat (3) @(negedge clk);
        chk(gnt == '0, "R1", "grant in reset", int'(gnt), 0);
        chk(inh == 1'b0, "R1", "inhibit in reset", int'(inh), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(gnt == '0 && !inh, "R1", "idle after reset", int'(gnt), 0);

        // R2/R3: chain order inside level 1, grant latency
        expect_g(4, "R2");
        expect_g(5, "R2");
        @(negedge clk);
        req[4] = 1'b1; req[5] = 1'b1;
        @(negedge clk);
        chk(gnt == NT'(1) << 4, "R3", "grant one cycle after request", int'(gnt), 16);
        wait_quiet();

        // R4: fixed order across levels
        expect_g(0, "R4"); expect_g(6, "R4"); expect_g(9, "R4");
        @(negedge clk);
        req[0] = 1'b1; req[6] = 1'b1; req[9] = 1'b1;
        wait_quiet();

        // R7/R9: preemption by a higher level in fixed mode
        hold[6] = 20; hold[1] = 3;
        expect_g(6, "R7"); expect_g(1, "R7"); expect_g(6, "R7");
        @(negedge clk);
        req[6] = 1'b1;
        repeat (3) @(negedge clk);
        req[1] = 1'b1;
        @(negedge clk);
        chk(inh == 1'b1, "R7", "inhibit after higher request", int'(inh), 1);
        @(negedge clk);
        chk(inh == 1'b0, "R9", "inhibit falls after busy drops", int'(inh), 0);
        chk(gnt == '0, "R9", "no grant in release cycle", int'(gnt), 0);
        wait_quiet();

        // R5: rotating order
        cfg(2'd1, 0);
        hold[6] = 2;
        expect_g(6, "R5");
        @(negedge clk);
        req[6] = 1'b1;
        wait_quiet();
        expect_g(9, "R5"); expect_g(0, "R5"); expect_g(3, "R5");
        @(negedge clk);
        req[0] = 1'b1; req[3] = 1'b1; req[9] = 1'b1;
        wait_quiet();

        // R6: round-robin pointer, no request preemption
        cfg(2'd2, 0);
        hold[3] = 2; hold[9] = 2;
        expect_g(3, "R6"); expect_g(9, "R6");
        @(negedge clk);
        req[3] = 1'b1; req[9] = 1'b1;
        wait_quiet();
        hold[6] = 5; hold[0] = 2;
        expect_g(6, "R6"); expect_g(0, "R6");
        @(negedge clk);
        req[6] = 1'b1; req[0] = 1'b1;
        wait_quiet();

        // R8: tenure limit of 4
        cfg(2'd0, 4);
        hold[7] = 30;
        expect_g(7, "R8"); expect_g(7, "R8");
        @(negedge clk);
        req[7] = 1'b1;
        do @(negedge clk); while (gnt == '0);
        begin
            int n = 0;
            while (!inh && n < 100) begin
                @(negedge clk);
                n++;
            end
            chk(n == 5, "R8", "cycles from grant to inhibit", n, 5);
        end
        wait_quiet();

        // R10: mode written while owned is deferred
        cfg(2'd0, 0);
        hold[6] = 20; hold[0] = 3;
        expect_g(6, "R10"); expect_g(0, "R10"); expect_g(6, "R10");
        @(negedge clk);
        req[6] = 1'b1;
        repeat (3) @(negedge clk);
        cfg(2'd2, 0);
        req[0] = 1'b1;
        @(negedge clk);
        chk(inh == 1'b1, "R10", "old fixed mode still preempts", int'(inh), 1);
        @(negedge clk);
        chk(inh == 1'b0, "R9", "inhibit falls after release", int'(inh), 0);
        wait_quiet();

        chk(expq.size() == 0, "R2", "grants left unmatched", expq.size(), 0);
        chk(inh_rises == 3, "R7", "inhibit assertions", inh_rises, 3);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule